// File: doc/BRIEF.md
# Hazard-Checked Command Dispatcher for Decoupled Load, Execute and Store Controllers

This block sits between a host command port and three independent controllers: one that moves data into local memory (load), one that runs the compute array (execute), and one that moves results out (store). Each accepted command takes a slot in a small tracking buffer. The slot holds the target controller, a configuration flag, an opaque argument word, and two local-memory ranges. Each range is a start address and a row count. One range is read by the command (source) and one is written by it (destination). A row count of zero means the command has no range of that kind. Scratchpad and accumulator rows share one flat local address space, so a single range comparison covers both.

A waiting command is offered to its controller only when every older, still-incomplete command is free of conflict with it. Older commands for the same controller must already have been issued. Under that rule, the three controllers overlap their work whenever their ranges do not collide. Each controller reports completion by returning the slot number it received at issue. Slots may complete in any order. Slot space is reclaimed from the oldest end. A fence command never reaches a controller. It closes the host port until all earlier work has drained.

Top module: `cmd_hazard_queue`

## Requirements
- R1: After reset the host port is ready (`cmd_ready`=1) and no controller port offers a command (`iss_valid`=0).
- R2: A non-fence command with controller code 0 (load), 1 (execute) or 2 (store) is offered only on the issue port of that index. Its configuration flag (class code 1), argument, addresses and row counts appear unchanged, together with its slot number. An offer that is not taken stays valid with the same slot.
- R3: Commands for one controller are offered in the order the host port accepted them.
- R4: Commands for different controllers whose ranges do not intersect may be issued and outstanding at the same time.
- R5: A command whose source range intersects the destination range of an older incomplete command is held until that older command completes. Ranges are half-open, [addr, addr+rows), so ranges that only touch do not intersect.
- R6: A command whose destination range intersects the source range of an older incomplete command is held until that command completes.
- R7: A command whose destination range intersects the destination range of an older incomplete command is held until that command completes.
- R8: After a configuration command (class code 1) for a controller, later commands for that same controller are held until the configuration completes. Other controllers are unaffected.
- R9: Once a fence (class code 2) is accepted, `cmd_ready` stays low until every older command has completed. A fence is never offered on any issue port.
- R10: With all slots occupied, `cmd_ready` is low. A completion in the middle of the buffer does not reopen the port; completion of the oldest entry does.
- R11: A row count of zero creates no hazard.
- R12: Completions may arrive in any slot order, and each one frees its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Host command is taken this cycle |
| cmd_class | input | 2 | 0 operation, 1 configuration, 2 fence |
| cmd_unit | input | 2 | Target controller: 0 load, 1 execute, 2 store |
| cmd_arg | input | ARG_W | Opaque argument passed to the controller |
| cmd_src_addr | input | ADDR_W | First row read |
| cmd_src_rows | input | ROWS_W | Rows read (0 = none) |
| cmd_dst_addr | input | ADDR_W | First row written |
| cmd_dst_rows | input | ROWS_W | Rows written (0 = none) |
| iss_valid | output | 3 | Per-controller offer |
| iss_ready | input | 3 | Per-controller acceptance |
| iss_id | output | 3 x IDX_W | Slot number of each offer |
| iss_cfg | output | 3 | Offer is a configuration command |
| iss_arg | output | 3 x ARG_W | Argument of each offer |
| iss_src_addr | output | 3 x ADDR_W | Source start of each offer |
| iss_src_rows | output | 3 x ROWS_W | Source rows of each offer |
| iss_dst_addr | output | 3 x ADDR_W | Destination start of each offer |
| iss_dst_rows | output | 3 x ROWS_W | Destination rows of each offer |
| done_valid | input | 3 | Per-controller completion strobe |
| done_id | input | 3 x IDX_W | Slot being completed |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=10, ROWS_W=4 and ARG_W=8. With four slots, the full condition is reached with four outstanding loads, so the "middle completion keeps the port closed" case takes only a few commands. The 10-bit address space leaves room for disjoint test ranges. It also allows a touching-but-not-overlapping range pair to be placed right at a hazard boundary.

// File: rtl/chq_pkg.sv
// Shared encodings for the command dispatcher.
// Assumes three controllers; slot state uses a two-bit code.
package chq_pkg;

    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        UNIT_LOAD  = 2'd0,
        UNIT_EXEC  = 2'd1,
        UNIT_STORE = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        CLS_OP    = 2'd0,
        CLS_CFG   = 2'd1,
        CLS_FENCE = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_BUSY = 2'd2
    } slot_e;

endpackage

// File: rtl/chq_slot_table.sv
// Slot storage for outstanding commands: a circular buffer whose entries
// retire out of order. Assumes DEPTH is a power of two, push only when not
// full, issue only of WAIT slots and completion only of BUSY slots.
// The head pointer skips freed slots one per cycle.
module chq_slot_table
    import chq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 14,
    parameter int ROWS_W = 5,
    parameter int ARG_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 push,
    input  logic                                 push_cfg,
    input  logic [1:0]                           push_unit,
    input  logic [ARG_W-1:0]                     push_arg,
    input  logic [ADDR_W-1:0]                    push_src_addr,
    input  logic [ROWS_W-1:0]                    push_src_rows,
    input  logic [ADDR_W-1:0]                    push_dst_addr,
    input  logic [ROWS_W-1:0]                    push_dst_rows,
    input  logic [NUM_UNITS-1:0]                 iss_fire,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]      iss_slot,
    input  logic [NUM_UNITS-1:0]                 done_valid,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]      done_slot,
    output logic [DEPTH-1:0][1:0]                state,
    output logic [DEPTH-1:0][1:0]                unit,
    output logic [DEPTH-1:0]                     cfg,
    output logic [DEPTH-1:0][ARG_W-1:0]          arg,
    output logic [DEPTH-1:0][ADDR_W-1:0]         src_addr,
    output logic [DEPTH-1:0][ROWS_W-1:0]         src_rows,
    output logic [DEPTH-1:0][ADDR_W-1:0]         dst_addr,
    output logic [DEPTH-1:0][ROWS_W-1:0]         dst_rows,
    output logic [IDX_W-1:0]                     head_idx,
    output logic                                 full,
    output logic                                 empty
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head_q, tail_q;
    logic [IDX_W-1:0] tail_idx;
    logic             head_adv;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = ((tail_q - head_q) == PTR_W'(DEPTH));
    assign head_adv = !empty && (state[head_idx] == SLOT_FREE);

    // Pointer and slot-state update: push, issue, completion, head reclaim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            state  <= '0;
        end else begin
            if (push) begin
                state[tail_idx] <= SLOT_WAIT;
                tail_q          <= tail_q + 1'b1;
            end
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (iss_fire[u])   state[iss_slot[u]]  <= SLOT_BUSY;
                if (done_valid[u]) state[done_slot[u]] <= SLOT_FREE;
            end
            if (head_adv) head_q <= head_q + 1'b1;
        end
    end

    // Payload capture at the tail slot; contents matter only while occupied.
    always_ff @(posedge clk) begin
        if (push) begin
            unit[tail_idx]     <= push_unit;
            cfg[tail_idx]      <= push_cfg;
            arg[tail_idx]      <= push_arg;
            src_addr[tail_idx] <= push_src_addr;
            src_rows[tail_idx] <= push_src_rows;
            dst_addr[tail_idx] <= push_dst_addr;
            dst_rows[tail_idx] <= push_dst_rows;
        end
    end

    assert_no_push_when_full_R10: assert property (
        @(posedge clk) disable iff (!rst_n) full |-> !push);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_done_chk
        assert_done_hits_busy_R12: assert property (
            @(posedge clk) disable iff (!rst_n)
            done_valid[u] |-> (state[done_slot[u]] == SLOT_BUSY) &&
                              (unit[done_slot[u]] == 2'(u)));
    end

endmodule

// File: rtl/chq_hazard_matrix.sv
// Pairwise age and range comparison across all slots. A slot is blocked when
// some older occupied slot conflicts with it: read-after-write,
// write-after-read or write-after-write on intersecting half-open ranges; an
// unfinished configuration for the same controller; or an unissued older
// command for the same controller. Assumes ROWS_W <= ADDR_W.
module chq_hazard_matrix
    import chq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 14,
    parameter int ROWS_W = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][1:0]        state,
    input  logic [DEPTH-1:0][1:0]        unit,
    input  logic [DEPTH-1:0]             cfg,
    input  logic [DEPTH-1:0][ADDR_W-1:0] src_addr,
    input  logic [DEPTH-1:0][ROWS_W-1:0] src_rows,
    input  logic [DEPTH-1:0][ADDR_W-1:0] dst_addr,
    input  logic [DEPTH-1:0][ROWS_W-1:0] dst_rows,
    input  logic [IDX_W-1:0]             head_idx,
    output logic [DEPTH-1:0]             blocked
);
    localparam int EXT_W = ADDR_W + 1;

    // Half-open interval intersection; an empty range never intersects.
    function automatic logic ranges_meet(
        input logic [ADDR_W-1:0] a, input logic [ROWS_W-1:0] ra,
        input logic [ADDR_W-1:0] b, input logic [ROWS_W-1:0] rb);
        logic [EXT_W-1:0] a_end, b_end;
        a_end = {1'b0, a} + EXT_W'(ra);
        b_end = {1'b0, b} + EXT_W'(rb);
        return (ra != '0) && (rb != '0) &&
               ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
    endfunction

    logic [DEPTH-1:0][IDX_W-1:0] age;
    logic [DEPTH-1:0][DEPTH-1:0] pair_block;

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        localparam logic [IDX_W-1:0] SELF = IDX_W'(i);
        assign age[i] = SELF - head_idx;

        for (genvar j = 0; j < DEPTH; j++) begin : g_col
            if (i == j) begin : g_self
                assign pair_block[i][j] = 1'b0;
            end else begin : g_pair
                logic older, live, raw, war, waw, same_unit;
                assign older     = (age[j] < age[i]);
                assign live      = (state[j] != SLOT_FREE);
                assign raw       = ranges_meet(src_addr[i], src_rows[i], dst_addr[j], dst_rows[j]);
                assign war       = ranges_meet(dst_addr[i], dst_rows[i], src_addr[j], src_rows[j]);
                assign waw       = ranges_meet(dst_addr[i], dst_rows[i], dst_addr[j], dst_rows[j]);
                assign same_unit = (unit[i] == unit[j]) && (cfg[j] || state[j] == SLOT_WAIT);
                assign pair_block[i][j] = older && live && (raw || war || waw || same_unit);
            end
        end

        assign blocked[i] = |pair_block[i];
    end

endmodule

// File: rtl/chq_issue_select.sv
// Picks the single eligible waiting slot for one controller. Relies on the
// hazard matrix blocking every younger same-controller slot, so at most one
// candidate exists per controller.
module chq_issue_select
    import chq_pkg::*;
#(
    parameter int          DEPTH = 8,
    parameter logic [1:0]  UNIT  = 2'd0,
    localparam int         IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DEPTH-1:0][1:0] state,
    input  logic [DEPTH-1:0][1:0] unit,
    input  logic [DEPTH-1:0]      blocked,
    output logic                  valid,
    output logic [IDX_W-1:0]      slot
);
    logic [DEPTH-1:0] cand;

    // Candidate vector and encoded slot of the chosen entry.
    always_comb begin
        slot = '0;
        for (int k = 0; k < DEPTH; k++) begin
            cand[k] = (state[k] == SLOT_WAIT) && (unit[k] == UNIT) && !blocked[k];
            if (cand[k]) slot = IDX_W'(k);
        end
        valid = |cand;
    end

    assert_single_candidate_R3: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(cand));

endmodule

// File: rtl/cmd_hazard_queue.sv
// Top of the dispatcher. Accepts host commands into the slot table, tracks a
// pending fence that closes the host port until the buffer drains, and drives
// one issue port per controller from the selected slot. Assumes the host uses
// controller codes 0..2 only and controllers return each issued slot once.
module cmd_hazard_queue
    import chq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 14,
    parameter int ROWS_W = 5,
    parameter int ARG_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    output logic                              cmd_ready,
    input  logic [1:0]                        cmd_class,
    input  logic [1:0]                        cmd_unit,
    input  logic [ARG_W-1:0]                  cmd_arg,
    input  logic [ADDR_W-1:0]                 cmd_src_addr,
    input  logic [ROWS_W-1:0]                 cmd_src_rows,
    input  logic [ADDR_W-1:0]                 cmd_dst_addr,
    input  logic [ROWS_W-1:0]                 cmd_dst_rows,
    output logic [NUM_UNITS-1:0]              iss_valid,
    input  logic [NUM_UNITS-1:0]              iss_ready,
    output logic [NUM_UNITS-1:0][IDX_W-1:0]   iss_id,
    output logic [NUM_UNITS-1:0]              iss_cfg,
    output logic [NUM_UNITS-1:0][ARG_W-1:0]   iss_arg,
    output logic [NUM_UNITS-1:0][ADDR_W-1:0]  iss_src_addr,
    output logic [NUM_UNITS-1:0][ROWS_W-1:0]  iss_src_rows,
    output logic [NUM_UNITS-1:0][ADDR_W-1:0]  iss_dst_addr,
    output logic [NUM_UNITS-1:0][ROWS_W-1:0]  iss_dst_rows,
    input  logic [NUM_UNITS-1:0]              done_valid,
    input  logic [NUM_UNITS-1:0][IDX_W-1:0]   done_id
);
    logic                         accept, push, is_fence, fence_pend_q;
    logic                         full, empty;
    logic [IDX_W-1:0]             head_idx;
    logic [DEPTH-1:0][1:0]        state, unit;
    logic [DEPTH-1:0]             cfg, blocked;
    logic [DEPTH-1:0][ARG_W-1:0]  arg;
    logic [DEPTH-1:0][ADDR_W-1:0] src_addr, dst_addr;
    logic [DEPTH-1:0][ROWS_W-1:0] src_rows, dst_rows;
    logic [NUM_UNITS-1:0]         iss_fire;

    assign is_fence  = (cmd_class == CLS_FENCE);
    assign cmd_ready = !full && !fence_pend_q;
    assign accept    = cmd_valid && cmd_ready;
    assign push      = accept && !is_fence;
    assign iss_fire  = iss_valid & iss_ready;

    // Fence tracking: set on an accepted fence, cleared once the buffer is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fence_pend_q <= 1'b0;
        else if (accept && is_fence)    fence_pend_q <= 1'b1;
        else if (fence_pend_q && empty) fence_pend_q <= 1'b0;
    end

    chq_slot_table #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROWS_W(ROWS_W), .ARG_W(ARG_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_cfg(cmd_class == CLS_CFG), .push_unit(cmd_unit),
        .push_arg(cmd_arg),
        .push_src_addr(cmd_src_addr), .push_src_rows(cmd_src_rows),
        .push_dst_addr(cmd_dst_addr), .push_dst_rows(cmd_dst_rows),
        .iss_fire(iss_fire), .iss_slot(iss_id),
        .done_valid(done_valid), .done_slot(done_id),
        .state(state), .unit(unit), .cfg(cfg), .arg(arg),
        .src_addr(src_addr), .src_rows(src_rows),
        .dst_addr(dst_addr), .dst_rows(dst_rows),
        .head_idx(head_idx), .full(full), .empty(empty)
    );

    chq_hazard_matrix #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROWS_W(ROWS_W)
    ) u_hazard (
        .state(state), .unit(unit), .cfg(cfg),
        .src_addr(src_addr), .src_rows(src_rows),
        .dst_addr(dst_addr), .dst_rows(dst_rows),
        .head_idx(head_idx), .blocked(blocked)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_port
        chq_issue_select #(.DEPTH(DEPTH), .UNIT(2'(u))) u_sel (
            .clk(clk), .rst_n(rst_n),
            .state(state), .unit(unit), .blocked(blocked),
            .valid(iss_valid[u]), .slot(iss_id[u])
        );

        assign iss_cfg[u]      = cfg[iss_id[u]];
        assign iss_arg[u]      = arg[iss_id[u]];
        assign iss_src_addr[u] = src_addr[iss_id[u]];
        assign iss_src_rows[u] = src_rows[iss_id[u]];
        assign iss_dst_addr[u] = dst_addr[iss_id[u]];
        assign iss_dst_rows[u] = dst_rows[iss_id[u]];

        assert_offer_held_R2: assert property (
            @(posedge clk) disable iff (!rst_n)
            (iss_valid[u] && !iss_ready[u]) |=> (iss_valid[u] && $stable(iss_id[u])));
    end

    assert_fence_closes_port_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (accept && is_fence) |=> !cmd_ready);

    assert_unit_code_legal_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        push |-> (cmd_unit != 2'd3));

endmodule

// File: tb/cmd_hazard_queue_tb.sv
module cmd_hazard_queue_tb;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 10;
    localparam int ROWS_W = 4;
    localparam int ARG_W  = 8;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int NU     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                       cmd_valid = 1'b0, cmd_ready;
    logic [1:0]                 cmd_class = '0, cmd_unit = '0;
    logic [ARG_W-1:0]           cmd_arg = '0;
    logic [ADDR_W-1:0]          cmd_src_addr = '0, cmd_dst_addr = '0;
    logic [ROWS_W-1:0]          cmd_src_rows = '0, cmd_dst_rows = '0;
    logic [NU-1:0]              iss_valid, iss_cfg;
    logic [NU-1:0]              iss_ready = '1;
    logic [NU-1:0][IDX_W-1:0]   iss_id;
    logic [NU-1:0][ARG_W-1:0]   iss_arg;
    logic [NU-1:0][ADDR_W-1:0]  iss_src_addr, iss_dst_addr;
    logic [NU-1:0][ROWS_W-1:0]  iss_src_rows, iss_dst_rows;
    logic [NU-1:0]              done_valid = '0;
    logic [NU-1:0][IDX_W-1:0]   done_id = '0;

    cmd_hazard_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROWS_W(ROWS_W), .ARG_W(ARG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_class(cmd_class), .cmd_unit(cmd_unit), .cmd_arg(cmd_arg),
        .cmd_src_addr(cmd_src_addr), .cmd_src_rows(cmd_src_rows),
        .cmd_dst_addr(cmd_dst_addr), .cmd_dst_rows(cmd_dst_rows),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id), .iss_cfg(iss_cfg),
        .iss_arg(iss_arg), .iss_src_addr(iss_src_addr), .iss_src_rows(iss_src_rows),
        .iss_dst_addr(iss_dst_addr), .iss_dst_rows(iss_dst_rows),
        .done_valid(done_valid), .done_id(done_id));

    typedef struct { int arg; logic [63:0] word; } exp_t;
    exp_t q_load[$], q_exec[$], q_store[$];

    int  checks = 0, errors = 0, cycles = 0;
    bit  finished = 0;
    bit  issued [256];
    int  id_of  [256];
    int  unit_of[256];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] pack(input logic c, input int a, input int sa, input int sr,
                                         input int da, input int dr);
        return 64'({c, ARG_W'(a), ADDR_W'(sa), ROWS_W'(sr), ADDR_W'(da), ROWS_W'(dr)});
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Driver: records the expected offer in the scoreboard, then hands the command over.
    task automatic send(input int cls, input int unit, input int a,
                        input int sa, input int sr, input int da, input int dr);
        exp_t e;
        if (cls != 2) begin
            e.arg  = a;
            e.word = pack(cls == 1, a, sa, sr, da, dr);
            unit_of[a] = unit;
            issued[a]  = 0;
            case (unit)
                0: q_load.push_back(e);
                1: q_exec.push_back(e);
                default: q_store.push_back(e);
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_class = 2'(cls); cmd_unit = 2'(unit); cmd_arg = ARG_W'(a);
        cmd_src_addr = ADDR_W'(sa); cmd_src_rows = ROWS_W'(sr);
        cmd_dst_addr = ADDR_W'(da); cmd_dst_rows = ROWS_W'(dr);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Controller model: completes the command carrying tag a once it has been issued.
    task automatic complete(input int a);
        while (!issued[a]) @(negedge clk);
        @(negedge clk);
        done_valid[unit_of[a]] = 1'b1;
        done_id[unit_of[a]]    = IDX_W'(id_of[a]);
        @(negedge clk);
        done_valid = '0;
    endtask

    // Monitor: every offer is taken (ready held high) and compared in order (R2, R3).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < NU; u++) begin
                if (iss_valid[u]) begin
                    exp_t e;
                    logic [63:0] act;
                    bit   have;
                    act = pack(iss_cfg[u], int'(iss_arg[u]), int'(iss_src_addr[u]),
                               int'(iss_src_rows[u]), int'(iss_dst_addr[u]), int'(iss_dst_rows[u]));
                    have = 1;
                    case (u)
                        0: if (q_load.size()  > 0) e = q_load.pop_front();  else have = 0;
                        1: if (q_exec.size()  > 0) e = q_exec.pop_front();  else have = 0;
                        default: if (q_store.size() > 0) e = q_store.pop_front(); else have = 0;
                    endcase
                    if (!have) chk("R2 unexpected offer", act, 64'hFFFF_FFFF_FFFF_FFFF);
                    else begin
                        chk("R2/R3 offer contents and order", act, e.word);
                        issued[e.arg] = 1;
                        id_of[e.arg]  = int'(iss_id[u]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run becomes a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        chk("R1 ready after reset", cmd_ready, 1);
        chk("R1 no offer after reset", iss_valid, 0);

        // R4: disjoint load and store outstanding together.
        send(0, 0, 1, 0, 0, 'h000, 4);
        send(0, 2, 2, 'h040, 2, 0, 0);
        settle(3);
        chk("R4 load issued", issued[1], 1);
        chk("R4 store issued while load incomplete", issued[2], 1);
        complete(1); complete(2);

        // R5: read after write, with a touching range that must pass.
        send(0, 0, 3, 0, 0, 'h100, 8);
        send(0, 1, 4, 'h104, 2, 'h300, 1);
        send(0, 2, 5, 'h108, 2, 0, 0);
        settle(3);
        chk("R5 overlapping read held", issued[4], 0);
        chk("R5 adjacent read not held", issued[5], 1);
        complete(3);
        settle(3);
        chk("R5 read released after completion", issued[4], 1);
        complete(4); complete(5);

        // R6: write after read.
        send(0, 2, 6, 'h200, 4, 0, 0);
        send(0, 0, 7, 0, 0, 'h203, 2);
        settle(3);
        chk("R6 write held behind older read", issued[7], 0);
        complete(6);
        settle(3);
        chk("R6 write released", issued[7], 1);
        complete(7);

        // R7: write after write.
        send(0, 0, 8, 0, 0, 'h180, 4);
        send(0, 1, 9, 0, 0, 'h183, 1);
        settle(3);
        chk("R7 write held behind older write", issued[9], 0);
        complete(8);
        settle(3);
        chk("R7 write released", issued[9], 1);
        complete(9);

        // R11: zero-row range ignores a live overlapping write.
        send(0, 0, 10, 0, 0, 'h020, 4);
        send(0, 1, 11, 'h020, 0, 'h020, 0);
        settle(3);
        chk("R11 empty range not held", issued[11], 1);
        complete(10); complete(11);

        // R8: configuration orders its own controller only.
        send(1, 1, 12, 0, 0, 0, 0);
        send(0, 1, 13, 0, 0, 0, 0);
        send(0, 0, 14, 0, 0, 0, 0);
        settle(3);
        chk("R8 config issued", issued[12], 1);
        chk("R8 same-controller command held", issued[13], 0);
        chk("R8 other controller not held", issued[14], 1);
        complete(12);
        settle(3);
        chk("R8 command released after config", issued[13], 1);
        complete(13); complete(14);

        // R3 and R12: in-order issue, reverse-order completion.
        send(0, 0, 15, 0, 0, 0, 0);
        send(0, 0, 16, 0, 0, 0, 0);
        send(0, 0, 17, 0, 0, 0, 0);
        settle(4);
        chk("R3 third load issued", issued[17], 1);
        complete(17); complete(16); complete(15);
        settle(6);
        chk("R12 port open after out-of-order completion", cmd_ready, 1);

        // R9: fence closes the port until drained.
        send(0, 0, 18, 0, 0, 'h050, 1);
        send(2, 0, 99, 0, 0, 0, 0);
        settle(1);
        chk("R9 port closed after fence", cmd_ready, 0);
        settle(4);
        chk("R9 port still closed while work outstanding", cmd_ready, 0);
        complete(18);
        settle(6);
        chk("R9 port reopens after drain", cmd_ready, 1);

        // R10: full buffer, hole in the middle, then oldest completes.
        send(0, 0, 19, 0, 0, 0, 0);
        send(0, 0, 20, 0, 0, 0, 0);
        send(0, 0, 21, 0, 0, 0, 0);
        send(0, 0, 22, 0, 0, 0, 0);
        settle(2);
        chk("R10 ready low when full", cmd_ready, 0);
        complete(20);
        settle(4);
        chk("R10 middle completion keeps port closed", cmd_ready, 0);
        complete(19);
        settle(4);
        chk("R10 oldest completion reopens port", cmd_ready, 1);
        complete(21); complete(22);
        settle(6);

        chk("R3 all expected load offers seen", q_load.size(), 0);
        chk("R3 all expected execute offers seen", q_exec.size(), 0);
        chk("R3 all expected store offers seen", q_store.size(), 0);
        chk("R12 port open at end", cmd_ready, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule